// File: doc/BRIEF.md
# Input Sample Rate Measurement Unit

This block estimates the sampling frequency of a received digital audio stream. It counts cycles of a fixed reference clock between successive frame strobes from the receiver. The reference clock is first divided by a prescaler, so that an 8-bit count covers every standard rate above 24 kHz. Each finished measurement is also classed into a 4-bit rate code.

A measurement is published only after two consecutive measurements agree. It can then be read from output ports, or through a one-address register read port.

Two modes are available:
- **Continuous mode:** the block re-measures on every frame, whatever the lock state. It therefore follows rate drift that the receiver PLL can still track.
- **Auto-stop mode:** the block measures only while the PLL error flag is high. When the flag drops, the last published result is frozen and stays frozen until the error flag rises again.

With the default parameters (24.576 MHz reference, divide by 4), the nominal counts are:

| Rate (kHz) | Nominal count |
|---|---|
| 32 | 192 |
| 44.1 | 139 |
| 48 | 128 |
| 88.2 | 70 |
| 96 | 64 |
| 176.4 | 35 |
| 192 | 32 |

Top module: `srate_meter`

## Requirements
- R1: After a synchronous reset, rate_count, rate_code, over_range and result_valid are all 0, and the read port returns 0.
- R2: A measurement is the number of prescaled ticks between two strobes: floor(P/DIV) for a strobe spacing of P clock cycles. The first strobe after the measuring gate opens only starts a new count.
- R3: A count that would reach 256 or more saturates at 255 and sets over_range (with rate_code 0). A count of exactly 255 leaves over_range at 0.
- R4: The rate code is set by a window around each nominal count. The window is nominal ± max(1, nominal/32), and the codes are:
  - code 1 = 32 kHz (186..198)
  - code 2 = 44.1 kHz (135..143)
  - code 3 = 48 kHz (124..132)
  - code 4 = 88.2 kHz (68..72)
  - code 5 = 96 kHz (62..66)
  - code 6 = 176.4 kHz (34..36)
  - code 7 = 192 kHz (31..33)
- R5: A count outside every window gives code 0, while result_valid is still set to 1.
- R6: The outputs are updated only when two consecutive measurements have equal count and equal overflow. A single differing measurement does not change the published result.
- R7: With cont_mode=1, measuring continues regardless of pll_err, and the outputs follow a change of rate.
- R8: With cont_mode=0, the block measures only while pll_err=1. While pll_err=0, the published outputs keep their values, and no new frames change them.
- R9: The read port answers one cycle after rd_addr is presented. At address 0xEB it returns:
  - bits 15..8: rate_count
  - bits 7..4: rate_code
  - bits 3..2: 0
  - bit 1: over_range
  - bit 0: result_valid

  Every other address returns 0.
- R10: A confirming strobe sampled at clock edge N changes the outputs at edge N+1, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed reference clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| pll_err | input | 1 | Receiver PLL error/unlock flag, 1 = unlocked |
| cont_mode | input | 1 | 1 = continuous measurement, 0 = auto-stop |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 16 | Registered read data |
| rate_count | output | 8 | Published raw count |
| rate_code | output | 4 | Published rate class code |
| over_range | output | 1 | Published count saturated |
| result_valid | output | 1 | A result has been published since reset |

## Verification
A strobe sampled at edge N is captured as a measurement at that edge. If the strobe confirms the previous measurement, it is published at edge N+1. Read data appears one edge after the address.

The bench drives every input on the falling edge, and samples on falling edges. The latency test therefore checks that the old value is still present one falling edge after the confirming strobe, and that the new value is present on the next falling edge. All other checks are taken at least one full frame after the last strobe, so they never sit on an update edge.

Strobe spacings are chosen so that each expected count is floor(P/DIV), read straight from the window table in R4.

// File: rtl/srate_pkg.sv
package srate_pkg;
  localparam int CNT_W     = 8;
  localparam int CODE_W    = 4;
  localparam int NUM_RATES = 7;

  // Nominal frame rates in Hz, indexed by code-1.
  function automatic int rate_hz(input int idx);
    case (idx)
      0:       return 32000;
      1:       return 44100;
      2:       return 48000;
      3:       return 88200;
      4:       return 96000;
      5:       return 176400;
      default: return 192000;
    endcase
  endfunction

  // Rounded number of prescaled ticks expected per frame.
  function automatic int nominal_count(input int ref_hz, input int div, input int fs_hz);
    return (ref_hz + (div * fs_hz) / 2) / (div * fs_hz);
  endfunction

  function automatic int window_tol(input int nom);
    return (nom / 32 < 1) ? 1 : nom / 32;
  endfunction
endpackage

// File: rtl/srate_period_counter.sv
module srate_period_counter #(
  parameter int DIV   = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate,
  input  logic             stb,
  output logic             meas_done,
  output logic [CNT_W-1:0] meas_cnt,
  output logic             meas_ovf
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [PW-1:0]    pre;
  logic [CNT_W-1:0] cnt;
  logic             sat;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre       <= '0;
      cnt       <= '0;
      sat       <= 1'b0;
      armed     <= 1'b0;
      meas_done <= 1'b0;
      meas_cnt  <= '0;
      meas_ovf  <= 1'b0;
    end else begin
      meas_done <= 1'b0;
      if (!gate) begin
        armed <= 1'b0;
        pre   <= '0;
        cnt   <= '0;
        sat   <= 1'b0;
      end else if (stb) begin
        // The strobe cycle is the first cycle of the new frame.
        armed     <= 1'b1;
        meas_done <= armed;
        meas_cnt  <= sat ? CMAX : cnt;
        meas_ovf  <= sat;
        pre       <= PW'(1);
        cnt       <= '0;
        sat       <= 1'b0;
      end else if (pre == PW'(DIV - 1)) begin
        pre <= '0;
        if (cnt == CMAX) sat <= 1'b1;
        else             cnt <= cnt + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end
endmodule

// File: rtl/srate_classifier.sv
module srate_classifier #(
  parameter int REF_HZ = 24576000,
  parameter int DIV    = 4,
  parameter int CNT_W  = 8,
  parameter int CODE_W = 4
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic              ovf,
  output logic [CODE_W-1:0] code
);
  localparam int NR = srate_pkg::NUM_RATES;

  logic [NR-1:0] hit;

  generate
    for (genvar i = 0; i < NR; i++) begin : g_win
      localparam int NOM = srate_pkg::nominal_count(REF_HZ, DIV, srate_pkg::rate_hz(i));
      localparam int TOL = srate_pkg::window_tol(NOM);
      localparam int LO  = NOM - TOL;
      localparam int HI  = NOM + TOL;
      assign hit[i] = !ovf && (int'({1'b0, cnt}) >= LO) && (int'({1'b0, cnt}) <= HI);
    end
  endgenerate

  always_comb begin
    code = '0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (hit[i]) code = CODE_W'(i + 1);
    end
  end
endmodule

// File: rtl/srate_result_filter.sv
module srate_result_filter #(
  parameter int CNT_W  = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate,
  input  logic              meas_done,
  input  logic [CNT_W-1:0]  meas_cnt,
  input  logic              meas_ovf,
  input  logic [CODE_W-1:0] meas_code,
  output logic [CNT_W-1:0]  pub_cnt,
  output logic [CODE_W-1:0] pub_code,
  output logic              pub_ovf,
  output logic              pub_valid
);
  logic [CNT_W-1:0] prev_cnt;
  logic             prev_ovf;
  logic             prev_ok;
  logic             agree;

  assign agree = prev_ok && (prev_cnt == meas_cnt) && (prev_ovf == meas_ovf);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cnt  <= '0;
      prev_ovf  <= 1'b0;
      prev_ok   <= 1'b0;
      pub_cnt   <= '0;
      pub_code  <= '0;
      pub_ovf   <= 1'b0;
      pub_valid <= 1'b0;
    end else if (!gate) begin
      prev_ok <= 1'b0;
    end else if (meas_done) begin
      prev_cnt <= meas_cnt;
      prev_ovf <= meas_ovf;
      prev_ok  <= 1'b1;
      if (agree) begin
        pub_cnt   <= meas_cnt;
        pub_code  <= meas_code;
        pub_ovf   <= meas_ovf;
        pub_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/srate_meter.sv
module srate_meter #(
  parameter int          REF_HZ   = 24576000,
  parameter int          DIV      = 4,
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'hEB
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          frame_stb,
  input  logic                          pll_err,
  input  logic                          cont_mode,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [15:0]                   rd_data,
  output logic [srate_pkg::CNT_W-1:0]   rate_count,
  output logic [srate_pkg::CODE_W-1:0]  rate_code,
  output logic                          over_range,
  output logic                          result_valid
);
  localparam int CW = srate_pkg::CNT_W;
  localparam int KW = srate_pkg::CODE_W;

  logic          gate;
  logic          m_done;
  logic [CW-1:0] m_cnt;
  logic          m_ovf;
  logic [KW-1:0] m_code;

  assign gate = cont_mode | pll_err;

  srate_period_counter #(.DIV(DIV), .CNT_W(CW)) u_cnt (
    .clk(clk), .rst(rst), .gate(gate), .stb(frame_stb),
    .meas_done(m_done), .meas_cnt(m_cnt), .meas_ovf(m_ovf)
  );

  srate_classifier #(.REF_HZ(REF_HZ), .DIV(DIV), .CNT_W(CW), .CODE_W(KW)) u_cls (
    .cnt(m_cnt), .ovf(m_ovf), .code(m_code)
  );

  srate_result_filter #(.CNT_W(CW), .CODE_W(KW)) u_flt (
    .clk(clk), .rst(rst), .gate(gate), .meas_done(m_done),
    .meas_cnt(m_cnt), .meas_ovf(m_ovf), .meas_code(m_code),
    .pub_cnt(rate_count), .pub_code(rate_code),
    .pub_ovf(over_range), .pub_valid(result_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_addr == ADDR_W'(REG_ADDR)) begin
      rd_data <= {rate_count, rate_code, 2'b00, over_range, result_valid};
    end else begin
      rd_data <= '0;
    end
  end
endmodule

// File: rtl/srate_meter_chk.sv
module srate_meter_chk #(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] REG_ADDR = 8'hEB
) (
  input logic              clk,
  input logic              rst,
  input logic              pll_err,
  input logic              cont_mode,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [15:0]       rd_data,
  input logic [7:0]        rate_count,
  input logic [3:0]        rate_code,
  input logic              over_range,
  input logic              result_valid
);
  // R8: a closed gate freezes every published output
  assert_hold_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (!cont_mode && !pll_err) |=> $stable({rate_count, rate_code, over_range, result_valid}));

  // R3: a saturated result carries full count and no class
  assert_sat_result_R3: assert property (@(posedge clk) disable iff (rst)
    over_range |-> (rate_count == 8'hFF && rate_code == 4'd0 && result_valid));

  // R4: only seven codes exist, and a class is never shown without a result
  assert_code_range_R4: assert property (@(posedge clk) disable iff (rst)
    (rate_code != 4'd0) |-> (rate_code <= 4'd7 && result_valid));

  // R1: once a result is published it stays valid until reset
  assert_valid_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> result_valid);

  // R9: read port returns the published fields one cycle later
  assert_read_hit_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_W'(REG_ADDR)) |=>
      (rd_data == {$past(rate_count), $past(rate_code), 2'b00, $past(over_range), $past(result_valid)}));

  assert_read_miss_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_addr != ADDR_W'(REG_ADDR)) |=> (rd_data == 16'h0000));
endmodule

bind srate_meter srate_meter_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst(rst), .pll_err(pll_err), .cont_mode(cont_mode),
  .rd_addr(rd_addr), .rd_data(rd_data), .rate_count(rate_count),
  .rate_code(rate_code), .over_range(over_range), .result_valid(result_valid)
);

// File: tb/tb_srate_meter.sv
`timescale 1ns/1ps
module tb_srate_meter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_stb = 1'b0;
  logic        pll_err = 1'b0;
  logic        cont_mode = 1'b0;
  logic [7:0]  rd_addr = 8'h00;
  logic [15:0] rd_data;
  logic [7:0]  rate_count;
  logic [3:0]  rate_code;
  logic        over_range;
  logic        result_valid;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  srate_meter dut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .pll_err(pll_err),
    .cont_mode(cont_mode), .rd_addr(rd_addr), .rd_data(rd_data),
    .rate_count(rate_count), .rate_code(rate_code),
    .over_range(over_range), .result_valid(result_valid)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int cnt, input int code, input int ovf, input int vld);
    chk(req, "rate_count", int'(rate_count), cnt);
    chk(req, "rate_code", int'(rate_code), code);
    chk(req, "over_range", int'(over_range), ovf);
    chk(req, "result_valid", int'(result_valid), vld);
  endtask

  // n strobes spaced p cycles apart; starts and ends on a falling edge
  task automatic frames(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      repeat (p - 1) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk_out("R1", 0, 0, 0, 0);
    chk("R1", "rd_data", int'(rd_data), 0);
  endtask

  task automatic t_gated;
    cont_mode = 1'b0; pll_err = 1'b0;
    frames(512, 4);
    chk_out("R8", 0, 0, 0, 0);
  endtask

  task automatic t_basic;
    cont_mode = 1'b1; pll_err = 1'b0;   // R7: continuous ignores lock
    frames(512, 3);                     // R2: 512/4 = 128 -> 48 kHz
    chk_out("R2", 128, 3, 0, 1);
  endtask

  task automatic t_latency;
    frames(557, 2);
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    chk("R10", "count one edge after strobe", int'(rate_count), 128);
    @(negedge clk);
    chk("R10", "count two edges after strobe", int'(rate_count), 139);
    chk("R7", "code follows rate change", int'(rate_code), 2);
    repeat (557 - 2) @(negedge clk);
  endtask

  task automatic t_table;
    frames(768, 3); chk_out("R4", 192, 1, 0, 1);
    frames(280, 3); chk_out("R4", 70, 4, 0, 1);
    frames(256, 3); chk_out("R4", 64, 5, 0, 1);
    frames(140, 3); chk_out("R4", 35, 6, 0, 1);
    frames(128, 3); chk_out("R4", 32, 7, 0, 1);
    frames(496, 3); chk_out("R4", 124, 3, 0, 1);
  endtask

  task automatic t_nomatch;
    frames(400, 3); chk_out("R5", 100, 0, 0, 1);
    frames(532, 3); chk_out("R5", 133, 0, 0, 1);
  endtask

  task automatic t_sat;
    frames(1020, 3); chk_out("R3", 255, 0, 0, 1);
    frames(1024, 3); chk_out("R3", 255, 0, 1, 1);
    frames(1100, 3); chk_out("R3", 255, 0, 1, 1);
  endtask

  task automatic t_glitch;
    frames(512, 3);
    chk_out("R6", 128, 3, 0, 1);
    frames(280, 1);
    frames(512, 1);   // this strobe closes a 70-count frame
    chk_out("R6", 128, 3, 0, 1);
    frames(512, 1);
    chk_out("R6", 128, 3, 0, 1);
  endtask

  task automatic t_hold;
    cont_mode = 1'b0; pll_err = 1'b1;
    frames(512, 3);
    chk_out("R8", 128, 3, 0, 1);
    frames(557, 3);
    chk_out("R8", 139, 2, 0, 1);
    pll_err = 1'b0;
    frames(512, 4);
    chk_out("R8", 139, 2, 0, 1);
    pll_err = 1'b1;
    frames(512, 3);
    chk_out("R8", 128, 3, 0, 1);
  endtask

  task automatic t_read;
    rd_addr = 8'hEB;
    @(negedge clk);
    chk("R9", "rd_data at 0xEB", int'(rd_data), (128 << 8) | (3 << 4) | 1);
    rd_addr = 8'hEA;
    @(negedge clk);
    chk("R9", "rd_data at 0xEA", int'(rd_data), 0);
    rd_addr = 8'hEB;
    cont_mode = 1'b1;
    frames(1100, 3);
    chk("R9", "rd_data saturated", int'(rd_data), (255 << 8) | 2 | 1);
    rd_addr = 8'h00;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_gated;
    t_basic;
    t_latency;
    t_table;
    t_nomatch;
    t_sat;
    t_glitch;
    t_hold;
    t_read;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule